// File: doc/BRIEF.md
# Paged Serial EEPROM Controller with Write Protection

This block is the memory side of a 256-byte serial presence-detect store held in a register array. A byte-level bus front end sits in front of it. The front end reports bus START and STOP conditions and every received byte. For each received byte the block answers with an acknowledge decision one cycle later. It also keeps a transmit byte ready for the front end to shift out. The block owns the byte address counter, a one-page write buffer, the timed write cycle that follows a STOP, sequential reads, and two flags that guard the lower half of the store against writes.

A memory write goes through the page buffer, which wraps within its page. The buffer is committed to the array only at STOP. The block then spends a fixed number of cycles busy and refuses every byte during that time. Protection commands use their own selection code. A permanent flag can only ever be set. A reversible flag can be set and cleared, but only while the high-voltage indication from the address pin stays active from START through STOP. A protection read returns its answer as ACK or NACK instead of as data.

The controller is one state machine with these states:
- `ST_IDLE`: waiting for START.
- `ST_DEV`: expecting the selection byte.
- `ST_WADDR`: expecting the word address.
- `ST_WDATA`: loading the page buffer.
- `ST_RDATA`: sending bytes.
- `ST_PADDR` and `ST_PDATA`: expecting the two dummy bytes of a protection command.
- `ST_PEND`: a protection command is waiting for STOP.
- `ST_SKIP`: not addressed until the next START or STOP.
- `ST_BUSY`: write cycle in progress.

Its transitions are:
- START moves every state except `ST_BUSY` to `ST_DEV`.
- STOP moves every state except `ST_BUSY` to `ST_IDLE`, or to `ST_BUSY` when a commit or a flag change is due.
- In `ST_DEV` a received byte moves to `ST_WADDR`, `ST_RDATA`, `ST_PADDR` or `ST_SKIP`.
- In `ST_WADDR` a received byte moves to `ST_WDATA`.
- In `ST_PADDR` a received byte moves to `ST_PDATA`, and in `ST_PDATA` to `ST_PEND`.
- `ST_BUSY` returns to `ST_IDLE` when its count expires.

Top module: `spd_store_ctrl`

## Requirements
- R1: After reset every byte of the store reads 0xFF and both protection flags are clear.
- R2: The address counter is 0x00 after reset. A received word address loads the counter: bits 7:4 select the page and bits 3:0 select the byte within it. A write that carries only a word address therefore sets where a following read starts.
- R3: Data bytes of a write go to the page buffer at the in-page offset, which increments and wraps from 15 to 0 within the page. A later byte overwrites an earlier byte at the same offset, and only the most recent contents are written.
- R4: Each byte handed to the front end (tx_done) advances the counter by one, wrapping from 0xFF to 0x00 across page boundaries.
- R5: A STOP after at least one data byte starts a write cycle of exactly WR_CYCLES clock cycles. During the cycle every received byte, including a selection byte, gets NACK and START is ignored. A write with no data bytes starts no cycle.
- R6: A selection byte is acknowledged for memory access only when bits 7:4 are 1010 and bits 3:1 equal strap_sel. Bit 0 = 1 selects read and bit 0 = 0 selects write. Any code other than 1010 or 0110 is answered with NACK.
- R7: While either flag is set, a write whose address has bit 7 = 0 is acknowledged byte by byte, changes no stored byte and starts no write cycle. Writes with bit 7 = 1 proceed normally.
- R8: A protection read (code 0110, bit 0 = 1) answers ACK when the addressed flag is clear and NACK when it is set, and sends no data.
- R9: With hv_flag active from START until STOP, selection byte 0110_001_0 sets the reversible flag and 0110_011_0 clears it, and 0110_001_1 reads it. Each change needs two dummy bytes and ends with a write cycle.
- R10: Without hv_flag at START, any 0110 write sets the permanent flag and any 0110 read reports it. If hv_flag drops before STOP, a reversible command changes nothing and starts no cycle.
- R11: Once set, the permanent flag stays set until reset. Any later 0110 write selection byte is then answered with NACK.
- R12: ack_valid pulses exactly in the cycle after each rx_valid, with ack_bit = 1 meaning ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_sel | input | 3 | Board strap value matched against selection bits 3:1 |
| hv_flag | input | 1 | Digital high-voltage indication from one address pin |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| rx_valid | input | 1 | One-cycle pulse with a received byte |
| rx_data | input | 8 | Received byte |
| tx_done | input | 1 | Pulse when the current transmit byte has been sent |
| ack_valid | output | 1 | Acknowledge decision valid |
| ack_bit | output | 1 | 1 = ACK, 0 = NACK |
| tx_data | output | 8 | Byte at the address counter, to be sent next |

## Verification
The selection decoder is swept over all 128 write-direction codes, which separates the memory code and the protection code from every other code and the matching strap from the seven others. Writes are tried as a single byte, as a 20-byte burst that wraps inside a page, as an address-only pointer set, and at the 0xFF/0x00 seam, each read back in sequence against a bench model. The write-cycle length is probed one cycle before and one cycle after its end, which tells a short busy period from a long one. The protection flags go through set, clear, dropped-indication and locked sequences, and lower-half and upper-half writes are compared after each step.

// File: rtl/spd_store_pkg.sv
package spd_store_pkg;

    localparam logic [3:0] PRE_MEM     = 4'b1010;
    localparam logic [3:0] PRE_WP      = 4'b0110;
    localparam logic [2:0] SEL_REV_SET = 3'b001;
    localparam logic [2:0] SEL_REV_CLR = 3'b011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA,
        ST_PADDR,
        ST_PDATA,
        ST_PEND,
        ST_SKIP,
        ST_BUSY
    } ctl_state_e;

    typedef enum logic [1:0] {
        WP_NONE,
        WP_SET_PERM,
        WP_SET_REV,
        WP_CLR_REV
    } wp_cmd_e;

endpackage

// File: rtl/spd_page_buf.sv
module spd_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DW     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         seed,
    input  logic [PAGE_W-1:0]            seed_off,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    output logic [PAGE_W-1:0]            cur_off,
    output logic [(1<<PAGE_W)*DW-1:0]    line,
    output logic [(1<<PAGE_W)-1:0]       line_mask
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [DW-1:0]     slot_q [SLOTS];
    logic [SLOTS-1:0]  mask_q;
    logic [PAGE_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            mask_q <= '0;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (seed) begin
            off_q  <= seed_off;
            mask_q <= '0;
        end else if (push) begin
            slot_q[off_q] <= push_data;
            mask_q[off_q] <= 1'b1;
            off_q         <= off_q + PAGE_W'(1);
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
        assign line[g*DW +: DW] = slot_q[g];
    end

    assign line_mask = mask_q;
    assign cur_off   = off_q;
endmodule

// File: rtl/spd_cell_array.sv
module spd_cell_array #(
    parameter int AW     = 8,
    parameter int PAGE_W = 4,
    parameter int DW     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [AW-PAGE_W-1:0]         commit_page,
    input  logic [(1<<PAGE_W)*DW-1:0]    line,
    input  logic [(1<<PAGE_W)-1:0]       line_mask,
    input  logic [AW-1:0]                raddr,
    output logic [DW-1:0]                rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int SLOTS = 1 << PAGE_W;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
        end else if (commit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (line_mask[s]) cell_q[{commit_page, PAGE_W'(s)}] <= line[s*DW +: DW];
            end
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/spd_store_ctrl.sv
module spd_store_ctrl
    import spd_store_pkg::*;
#(
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_sel,
    input  logic       hv_flag,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_done,
    output logic       ack_valid,
    output logic       ack_bit,
    output logic [7:0] tx_data
);
    localparam int AW    = 8;
    localparam int DW    = 8;
    localparam int SLOTS = 1 << PAGE_W;
    localparam int CW    = $clog2(WR_CYCLES + 1);

    ctl_state_e state_q, state_d;
    wp_cmd_e    cmd_q, cmd_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [CW-1:0] busy_cnt_q;
    logic pflag_q, rflag_q, hv_ok_q;
    logic ack_d, ack_valid_q, ack_bit_q;
    logic pb_seed, pb_push, commit, busy_load, set_perm, set_rev, clr_rev;
    logic [PAGE_W-1:0]     pb_off;
    logic [SLOTS*DW-1:0]   pb_line;
    logic [SLOTS-1:0]      pb_mask;
    logic [3:0] rx_pre;
    logic [2:0] rx_sel;
    logic       rx_rd, guarded, hv_live, rev_pick;

    assign rx_pre   = rx_data[7:4];
    assign rx_sel   = rx_data[3:1];
    assign rx_rd    = rx_data[0];
    assign guarded  = !addr_q[AW-1] && (pflag_q || rflag_q);
    assign hv_live  = hv_ok_q && hv_flag;
    assign rev_pick = hv_live && (rx_sel == SEL_REV_SET || (rx_sel == SEL_REV_CLR && !rx_rd));

    always_comb begin
        state_d   = state_q;
        cmd_d     = cmd_q;
        addr_d    = addr_q;
        ack_d     = 1'b0;
        pb_seed   = 1'b0;
        pb_push   = 1'b0;
        commit    = 1'b0;
        busy_load = 1'b0;
        set_perm  = 1'b0;
        set_rev   = 1'b0;
        clr_rev   = 1'b0;
        if (state_q == ST_BUSY) begin
            if (busy_cnt_q == '0) state_d = ST_IDLE;
        end else if (bus_stop) begin
            state_d = ST_IDLE;
            unique case (state_q)
                ST_WDATA: begin
                    if ((|pb_mask) && !guarded) begin
                        commit    = 1'b1;
                        busy_load = 1'b1;
                        state_d   = ST_BUSY;
                    end
                end
                ST_PEND: begin
                    if (cmd_q == WP_SET_PERM) begin
                        set_perm  = 1'b1;
                        busy_load = 1'b1;
                        state_d   = ST_BUSY;
                    end else if (hv_live) begin
                        set_rev   = (cmd_q == WP_SET_REV);
                        clr_rev   = (cmd_q == WP_CLR_REV);
                        busy_load = 1'b1;
                        state_d   = ST_BUSY;
                    end
                end
                default: ;
            endcase
        end else if (bus_start) begin
            state_d = ST_DEV;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_DEV: begin
                    state_d = ST_SKIP;
                    if (rx_pre == PRE_MEM && rx_sel == strap_sel) begin
                        ack_d   = 1'b1;
                        state_d = rx_rd ? ST_RDATA : ST_WADDR;
                    end else if (rx_pre == PRE_WP) begin
                        if (rx_rd) begin
                            ack_d = rev_pick ? !rflag_q : !pflag_q;
                        end else if (!pflag_q) begin
                            ack_d   = 1'b1;
                            state_d = ST_PADDR;
                            if (!rev_pick)                 cmd_d = WP_SET_PERM;
                            else if (rx_sel == SEL_REV_SET) cmd_d = WP_SET_REV;
                            else                           cmd_d = WP_CLR_REV;
                        end
                    end
                end
                ST_WADDR: begin
                    ack_d   = 1'b1;
                    addr_d  = rx_data;
                    pb_seed = 1'b1;
                    state_d = ST_WDATA;
                end
                ST_WDATA: begin
                    ack_d   = 1'b1;
                    pb_push = 1'b1;
                    addr_d  = {addr_q[AW-1:PAGE_W], pb_off + PAGE_W'(1)};
                end
                ST_PADDR: begin
                    ack_d   = 1'b1;
                    state_d = ST_PDATA;
                end
                ST_PDATA: begin
                    ack_d   = 1'b1;
                    state_d = ST_PEND;
                end
                default: ;
            endcase
        end else if (tx_done && state_q == ST_RDATA) begin
            addr_d = addr_q + AW'(1);
        end
    end

    spd_page_buf #(.PAGE_W(PAGE_W), .DW(DW)) u_page_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed      (pb_seed),
        .seed_off  (rx_data[PAGE_W-1:0]),
        .push      (pb_push),
        .push_data (rx_data),
        .cur_off   (pb_off),
        .line      (pb_line),
        .line_mask (pb_mask)
    );

    spd_cell_array #(.AW(AW), .PAGE_W(PAGE_W), .DW(DW)) u_cells (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_page (addr_q[AW-1:PAGE_W]),
        .line        (pb_line),
        .line_mask   (pb_mask),
        .raddr       (addr_q),
        .rdata       (tx_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cmd_q      <= WP_NONE;
            addr_q     <= '0;
            busy_cnt_q <= '0;
            pflag_q    <= 1'b0;
            rflag_q    <= 1'b0;
            hv_ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            if (busy_load)                              busy_cnt_q <= CW'(WR_CYCLES - 1);
            else if (state_q == ST_BUSY && busy_cnt_q != '0) busy_cnt_q <= busy_cnt_q - CW'(1);
            if (set_perm) pflag_q <= 1'b1;
            if (set_rev)  rflag_q <= 1'b1;
            else if (clr_rev) rflag_q <= 1'b0;
            if (bus_start)     hv_ok_q <= hv_flag;
            else if (!hv_flag) hv_ok_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid_q <= 1'b0;
            ack_bit_q   <= 1'b0;
        end else begin
            ack_valid_q <= rx_valid;
            ack_bit_q   <= rx_valid && ack_d;
        end
    end

    assign ack_valid = ack_valid_q;
    assign ack_bit   = ack_bit_q;
endmodule

// File: rtl/spd_store_chk.sv
module spd_store_chk
    import spd_store_pkg::*;
#(
    parameter int WR_CYCLES = 8,
    parameter int CW        = 4
) (
    input logic          clk,
    input logic          rst_n,
    input ctl_state_e    state,
    input logic          rx_valid,
    input logic          bus_start,
    input logic          bus_stop,
    input logic          tx_done,
    input logic          hv_flag,
    input logic          ack_valid,
    input logic          ack_bit,
    input logic [7:0]    addr,
    input logic [CW-1:0] busy_cnt,
    input logic          pflag,
    input logic          rflag,
    input logic          commit
);
    assert_ack_follows_rx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> ack_valid);

    assert_ack_has_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(rx_valid));

    assert_busy_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && rx_valid) |=> (ack_valid && !ack_bit));

    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> (busy_cnt < CW'(WR_CYCLES)));

    assert_read_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && tx_done && !rx_valid && !bus_start && !bus_stop)
        |=> (addr == 8'($past(addr) + 8'd1)));

    assert_perm_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pflag |=> pflag);

    assert_guard_blocks_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !(!addr[7] && (pflag || rflag)));

    assert_rev_needs_hv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rflag) |-> $past(hv_flag));
endmodule

bind spd_store_ctrl spd_store_chk #(.WR_CYCLES(WR_CYCLES), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .rx_valid  (rx_valid),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .tx_done   (tx_done),
    .hv_flag   (hv_flag),
    .ack_valid (ack_valid),
    .ack_bit   (ack_bit),
    .addr      (addr_q),
    .busy_cnt  (busy_cnt_q),
    .pflag     (pflag_q),
    .rflag     (rflag_q),
    .commit    (commit)
);

// File: tb/test_spd_store_ctrl.sv
module test_spd_store_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WR = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n, hv_flag, bus_start, bus_stop, rx_valid, tx_done;
    logic [7:0] rx_data;
    logic ack_valid, ack_bit;
    logic [7:0] tx_data;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] model [256];
    logic exp_p = 1'b0;
    logic exp_r = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spd_store_ctrl #(.PAGE_W(4), .WR_CYCLES(WR)) i_spd_store_ctrl (
        .clk(clk), .rst_n(rst_n), .strap_sel(STRAP), .hv_flag(hv_flag),
        .bus_start(bus_start), .bus_stop(bus_stop), .rx_valid(rx_valid),
        .rx_data(rx_data), .tx_done(tx_done), .ack_valid(ack_valid),
        .ack_bit(ack_bit), .tx_data(tx_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0; @(negedge clk);
    endtask

    task automatic do_stop();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0; @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b, output logic a);
        rx_data = b; rx_valid = 1'b1; @(negedge clk);
        rx_valid = 1'b0; a = ack_bit; @(negedge clk);
    endtask

    task automatic get(output logic [7:0] b);
        b = tx_data; tx_done = 1'b1; @(negedge clk);
        tx_done = 1'b0; @(negedge clk);
    endtask

    task automatic settle();
        repeat (WR + 4) @(negedge clk);
    endtask

    task automatic send_chk(input logic [7:0] b, input logic exp, input string req);
        logic a;
        put(b, a);
        chk(req, a, exp);
    endtask

    task automatic point(input logic [7:0] a, input string req);
        do_start(); send_chk(DEV_W, 1'b1, req); send_chk(a, 1'b1, req);
        do_start(); send_chk(DEV_R, 1'b1, req);
    endtask

    task automatic read_cmp(input logic [7:0] a, input int n, input string req);
        logic [7:0] b;
        point(a, req);
        for (int i = 0; i < n; i++) begin
            get(b);
            chk(req, b, model[8'(a + i)]);
        end
        do_stop();
    endtask

    task automatic write_run(input logic [7:0] a, input int n, input logic [7:0] base, input string req);
        do_start(); send_chk(DEV_W, 1'b1, req); send_chk(a, 1'b1, req);
        for (int i = 0; i < n; i++) begin
            send_chk(8'(base + i), 1'b1, req);
            if (!(a[7] == 1'b0 && (exp_p || exp_r)))
                model[{a[7:4], 4'(a[3:0] + i)}] = 8'(base + i);
        end
        do_stop();
    endtask

    task automatic wp_write(input logic [7:0] cmd, input logic hv, input logic exp, input string req);
        logic a;
        hv_flag = hv; do_start(); put(cmd, a); chk(req, a, exp);
        if (a) begin send_chk(8'h00, 1'b1, req); send_chk(8'h00, 1'b1, req); end
        do_stop(); hv_flag = 1'b0; settle();
    endtask

    task automatic wp_query(input logic [7:0] cmd, input logic hv, input logic exp, input string req);
        hv_flag = hv; do_start(); send_chk(cmd, exp, req); do_stop(); hv_flag = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        logic a;
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        rst_n = 1'b0; hv_flag = 1'b0; bus_start = 1'b0; bus_stop = 1'b0;
        rx_valid = 1'b0; tx_done = 1'b0; rx_data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; @(negedge clk);

        // R12 / R1 / R2: reset state
        chk("R12 reset ack_valid", ack_valid, 1'b0);
        chk("R2 counter at 0 reads R1 blank", tx_data, 8'hFF);

        // R1 / R4: immediate read over the whole store from the reset counter
        do_start(); send_chk(DEV_R, 1'b1, "R6 read select");
        for (int i = 0; i < 256; i++) begin get(b); chk("R1 blank byte", b, 8'hFF); end
        do_stop();

        // R6: sweep every write-direction selection code, flags clear
        for (int p = 0; p < 16; p++) begin
            for (int s = 0; s < 8; s++) begin
                do_start(); put({4'(p), 3'(s), 1'b0}, a);
                chk("R6 select sweep", a,
                    ((p == 10 && 3'(s) == STRAP) || p == 6) ? 1'b1 : 1'b0);
                do_stop();
            end
        end

        // R12: acknowledge pulse timing
        do_start();
        rx_data = DEV_W; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
        chk("R12 pulse after rx", ack_valid, 1'b1);
        @(negedge clk);
        chk("R12 single pulse", ack_valid, 1'b0);
        do_stop();

        // R5: busy window, probe one cycle before its end
        do_start(); send_chk(DEV_W, 1'b1, "R5"); send_chk(8'h85, 1'b1, "R5");
        send_chk(8'h3C, 1'b1, "R5"); model[8'h85] = 8'h3C;
        do_stop(); repeat (WR - 2) @(negedge clk);
        do_start(); send_chk(DEV_W, 1'b0, "R5 still busy"); do_stop();
        settle();
        // R5: probe one cycle after its end
        do_start(); send_chk(DEV_W, 1'b1, "R5"); send_chk(8'h86, 1'b1, "R5");
        send_chk(8'hC3, 1'b1, "R5"); model[8'h86] = 8'hC3;
        do_stop(); repeat (WR - 1) @(negedge clk);
        do_start(); send_chk(DEV_W, 1'b1, "R5 cycle over"); do_stop();
        read_cmp(8'h85, 2, "R2 readback");

        // R2 / R5: address-only write sets pointer, no write cycle
        do_start(); send_chk(DEV_W, 1'b1, "R2"); send_chk(8'h85, 1'b1, "R2"); do_stop();
        do_start(); send_chk(DEV_R, 1'b1, "R5 no cycle after pointer set");
        get(b); chk("R2 pointer read", b, 8'h3C); do_stop();

        // R3: 20 bytes into page 9 from offset 3, wrap within page
        write_run(8'h93, 20, 8'h40, "R3 burst");
        settle();
        read_cmp(8'h90, 17, "R3 page contents");

        // R4: seam 0xFF -> 0x00
        write_run(8'hFF, 1, 8'hA5, "R4"); settle();
        write_run(8'h00, 1, 8'h5A, "R4"); settle();
        read_cmp(8'hFF, 2, "R4 wrap");

        // R8: status reads with flags clear
        wp_query(8'h61, 1'b0, 1'b1, "R8 perm clear");
        wp_query(8'h63, 1'b1, 1'b1, "R8 rev clear");

        // R9: set reversible flag
        wp_write(8'h62, 1'b1, 1'b1, "R9 set rev"); exp_r = 1'b1;
        wp_query(8'h63, 1'b1, 1'b0, "R9 rev set");
        wp_query(8'h61, 1'b0, 1'b1, "R10 perm still clear");

        // R7: lower-half write acknowledged, ignored, no cycle
        write_run(8'h10, 1, 8'h77, "R7 guarded acks");
        do_start(); send_chk(DEV_R, 1'b1, "R7 no cycle"); do_stop();
        read_cmp(8'h10, 1, "R7 guarded unchanged");
        write_run(8'h90, 1, 8'h11, "R7 upper");
        do_start(); send_chk(DEV_W, 1'b0, "R7 upper starts cycle"); do_stop();
        settle();
        read_cmp(8'h90, 1, "R7 upper written");

        // R9: clear reversible flag
        wp_write(8'h66, 1'b1, 1'b1, "R9 clear rev"); exp_r = 1'b0;
        wp_query(8'h63, 1'b1, 1'b1, "R9 rev cleared");
        write_run(8'h10, 1, 8'h77, "R7 unguarded"); settle();
        read_cmp(8'h10, 1, "R7 unguarded written");

        // R10: indication dropped before STOP
        hv_flag = 1'b1; do_start(); send_chk(8'h62, 1'b1, "R10");
        send_chk(8'h00, 1'b1, "R10"); send_chk(8'h00, 1'b1, "R10");
        hv_flag = 1'b0; @(negedge clk); do_stop();
        wp_query(8'h63, 1'b1, 1'b1, "R10 dropped hv no change");

        // R10: same code without indication sets the permanent flag
        wp_write(8'h62, 1'b0, 1'b1, "R10 perm via rev code"); exp_p = 1'b1;
        wp_query(8'h61, 1'b0, 1'b0, "R10 perm set");
        wp_query(8'h63, 1'b1, 1'b1, "R10 rev untouched");

        // R11: locked
        wp_write(8'h60, 1'b0, 1'b0, "R11 perm again");
        wp_write(8'h62, 1'b1, 1'b0, "R11 rev set refused");
        wp_write(8'h66, 1'b1, 1'b0, "R11 rev clear refused");
        wp_query(8'h63, 1'b1, 1'b1, "R11 rev still clear");
        write_run(8'h20, 1, 8'h99, "R11 guarded"); settle();
        read_cmp(8'h20, 1, "R11 guarded unchanged");
        wp_query(8'h61, 1'b0, 1'b0, "R11 perm still set");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule